// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional Atomics

This block tracks which cache lines are reserved by a load-linked operation and by which requester, so that a later store-conditional can be told whether it may commit. Completed write-class operations arrive one per cycle on a strobe that carries the line address, an operation code and the requester identifier. One cycle later the block returns a response pulse with a success bit. Only a store-conditional can fail. All other operations report success.

A store-conditional succeeds only when its line holds a reservation owned by the same requester. Whatever the outcome, the store-conditional removes that reservation. An ordinary write-class completion by the owning requester also breaks the reservation. A small table of reservation records is kept, and the oldest record is displaced when it is full.

The block also keeps a short list of lines held by a locked read-modify-write sequence. The read half of the sequence places a hold on its line and the write half releases it. A query port reports whether a given line is currently held, so the request path can stall new requests to that line.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op code 1) always reports success 1 and leaves a reservation on its line owned by its requester identifier.
- R2: A store-conditional (op code 2) reports success 1 only if a reservation on its line exists with the same owner identifier, and 0 otherwise.
- R3: Every store-conditional removes any reservation on its line, whether it succeeded or failed, and whoever owned it.
- R4: An ordinary write-class operation (op codes 0 and 3 to 7) removes the reservation on its line only when that reservation is owned by the same requester. A reservation owned by another requester is left in place.
- R5: Every operation other than a store-conditional reports success 1.
- R6: A locked read-modify-write read (op code 3) places a hold on its line, and `qry_blocked` is 1 for that line from the next cycle on. A locked read-modify-write write (op code 4) to the line releases the hold.
- R7: At most NREC (default 4) reservations are held at once. A load-linked to a new line while the table is full displaces the reservation made longest ago.
- R8: A load-linked to a line that already holds a reservation replaces the owner identifier and does not renew the record's age for replacement purposes.
- R9: A synchronous active-low reset clears all reservations, all holds and the response outputs.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `cmp_valid` 1. `rsp_success` is 0 whenever `rsp_valid` is 0.
- R11: At most NBLK (default 2) lines are held at once. A locked read to a line already held, or a locked read while the hold list is full, adds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | A completed operation is presented this cycle |
| cmp_addr | input | AW | Line address of the operation |
| cmp_op | input | 3 | Operation code: 0 store, 1 load-linked, 2 store-conditional, 3 locked RMW read, 4 locked RMW write, 5 flush, 6 RMW read, 7 other write |
| cmp_owner | input | IW | Requester identifier |
| qry_addr | input | AW | Line address to test for a hold |
| rsp_valid | output | 1 | Response pulse, one cycle after the strobe |
| rsp_success | output | 1 | Success flag of the responded operation |
| qry_blocked | output | 1 | `qry_addr` is currently held by a locked read |

## Verification
The bench first runs directed pairs that separate the cases. A load-linked is followed by a store-conditional from the same owner and then from a different owner, and a second store-conditional after the first shows that even a failed one removes the reservation. Ordinary stores are then issued from the owner and from a stranger; only the owner's store should break the reservation. Five load-linked operations to distinct lines, with and without an owner overwrite in between, show whether replacement follows insertion order and ignores the overwrite. A long random phase over eight lines and four owners then mixes every op code and constantly collides addresses, with a behavioural model compared on every clock for the response and the hold query.

// File: rtl/llsc_pkg.sv
// Package: shared operation codes for the reservation monitor.
// Assumes a 3-bit op field on the completion strobe.
package llsc_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_STORE   = 3'd0,
        OP_LL      = 3'd1,
        OP_SC      = 3'd2,
        OP_LRMW_RD = 3'd3,
        OP_LRMW_WR = 3'd4,
        OP_FLUSH   = 3'd5,
        OP_RMW_RD  = 3'd6,
        OP_OTHER   = 3'd7
    } op_e;
endpackage

// File: rtl/llsc_lock_table.sv
// Module: reservation record table.
// Holds NREC records {line, owner, age}. The ages of valid records always
// form the ranks 0..n-1, where 0 is the newest insertion. A load-linked
// inserts or overwrites, a store-conditional removes on any hit, and a plain
// write removes on an owner-matching hit.
// Assumes at most one operation per cycle.
module llsc_lock_table #(
    parameter int AW   = 16,
    parameter int IW   = 4,
    parameter int NREC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_ll,
    input  logic          in_sc,
    input  logic [AW-1:0] in_addr,
    input  logic [IW-1:0] in_owner,
    output logic          out_owned
);
    localparam int SW = (NREC > 1) ? $clog2(NREC) : 1;

    logic [NREC-1:0] vld;
    logic [AW-1:0]   adr [NREC];
    logic [IW-1:0]   own [NREC];
    logic [SW-1:0]   age [NREC];

    logic [NREC-1:0] hit_vec;
    logic            any_hit, any_free;
    logic [SW-1:0]   hit_idx, free_idx, old_idx, hit_age;
    logic            ll_en, rem_en, dup_line;

    // Per-record address compare against the incoming line.
    genvar g;
    generate
        for (g = 0; g < NREC; g++) begin : g_cmp
            assign hit_vec[g] = vld[g] && (adr[g] == in_addr);
        end
    endgenerate

    // Locate the hit record, the lowest free slot and the oldest record.
    always_comb begin
        any_hit  = 1'b0;
        hit_idx  = '0;
        any_free = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = 0; i < NREC; i++) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = SW'(i);
            end
            if (!vld[i] && !any_free) begin
                any_free = 1'b1;
                free_idx = SW'(i);
            end
            if (vld[i] && (age[i] == SW'(NREC - 1))) old_idx = SW'(i);
        end
    end

    assign hit_age   = age[hit_idx];
    assign out_owned = any_hit && (own[hit_idx] == in_owner);
    assign ll_en     = in_valid && in_ll;
    assign rem_en    = in_valid && any_hit && (in_sc || (!in_ll && out_owned));

    // Update records: insert/overwrite on load-linked, remove on clear events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < NREC; i++) age[i] <= '0;
        end else if (ll_en) begin
            if (any_hit) begin
                own[hit_idx] <= in_owner;
            end else if (any_free) begin
                for (int i = 0; i < NREC; i++)
                    if (vld[i]) age[i] <= age[i] + SW'(1);
                vld[free_idx] <= 1'b1;
                adr[free_idx] <= in_addr;
                own[free_idx] <= in_owner;
                age[free_idx] <= '0;
            end else begin
                for (int i = 0; i < NREC; i++)
                    if (SW'(i) != old_idx) age[i] <= age[i] + SW'(1);
                adr[old_idx] <= in_addr;
                own[old_idx] <= in_owner;
                age[old_idx] <= '0;
            end
        end else if (rem_en) begin
            vld[hit_idx] <= 1'b0;
            for (int i = 0; i < NREC; i++)
                if (vld[i] && (age[i] > hit_age)) age[i] <= age[i] - SW'(1);
        end
    end

    // Detect two valid records naming the same line.
    always_comb begin
        dup_line = 1'b0;
        for (int i = 0; i < NREC; i++)
            for (int j = i + 1; j < NREC; j++)
                if (vld[i] && vld[j] && (adr[i] == adr[j])) dup_line = 1'b1;
    end

    AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_line); // R8

    generate
        for (g = 0; g < NREC; g++) begin : g_chk
            AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && in_sc && hit_vec[g] |=> !vld[g]); // R3
            AST_LL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && in_ll && hit_vec[g] |=> vld[g] && (own[g] == $past(in_owner))); // R8
            AST_AGE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
                vld[g] |-> (int'(age[g]) < $countones(vld))); // R7
        end
    endgenerate
endmodule

// File: rtl/llsc_block_table.sv
// Module: hold list for locked read-modify-write sequences.
// A set request places a hold on a line in the lowest free slot unless the
// line is already held or no slot is free; a clear request releases it.
// Assumes set and clear are never raised together.
module llsc_block_table #(
    parameter int AW   = 16,
    parameter int NBLK = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [AW-1:0] in_addr,
    input  logic [AW-1:0] qry_addr,
    output logic          qry_hit
);
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;

    logic [NBLK-1:0] vld;
    logic [AW-1:0]   adr [NBLK];
    logic [NBLK-1:0] in_match, q_match;
    logic            any_free;
    logic [BW-1:0]   free_idx;

    // Compare every hold against the operation line and the query line.
    genvar g;
    generate
        for (g = 0; g < NBLK; g++) begin : g_cmp
            assign in_match[g] = vld[g] && (adr[g] == in_addr);
            assign q_match[g]  = vld[g] && (adr[g] == qry_addr);
        end
    endgenerate

    // Find the lowest free slot.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NBLK; i++)
            if (!vld[i] && !any_free) begin
                any_free = 1'b1;
                free_idx = BW'(i);
            end
    end

    assign qry_hit = |q_match;

    // Place or release holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (set_en) begin
            if (!(|in_match) && any_free) begin
                vld[free_idx] <= 1'b1;
                adr[free_idx] <= in_addr;
            end
        end else if (clr_en) begin
            for (int i = 0; i < NBLK; i++)
                if (in_match[i]) vld[i] <= 1'b0;
        end
    end

    AST_BLK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_match)); // R11

    generate
        for (g = 0; g < NBLK; g++) begin : g_chk
            AST_BLK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                clr_en && in_match[g] |=> !vld[g]); // R6
        end
    endgenerate
endmodule

// File: rtl/llsc_monitor.sv
// Module: top of the reservation monitor.
// Decodes the operation code, drives the reservation table and the hold
// list, and registers a one-cycle-later response with the success flag.
// Assumes one completion per cycle and that the success of a
// store-conditional is judged on the table state before the update.
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int AW   = 16,
    parameter int IW   = 4,
    parameter int NREC = 4,
    parameter int NBLK = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid,
    input  logic [AW-1:0] cmp_addr,
    input  logic [2:0]    cmp_op,
    input  logic [IW-1:0] cmp_owner,
    input  logic [AW-1:0] qry_addr,
    output logic          rsp_valid,
    output logic          rsp_success,
    output logic          qry_blocked
);
    op_e  op;
    logic is_ll, is_sc, owned;

    assign op    = op_e'(cmp_op);
    assign is_ll = (op == OP_LL);
    assign is_sc = (op == OP_SC);

    llsc_lock_table #(.AW(AW), .IW(IW), .NREC(NREC)) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (cmp_valid),
        .in_ll     (is_ll),
        .in_sc     (is_sc),
        .in_addr   (cmp_addr),
        .in_owner  (cmp_owner),
        .out_owned (owned)
    );

    llsc_block_table #(.AW(AW), .NBLK(NBLK)) u_holds (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (cmp_valid && (op == OP_LRMW_RD)),
        .clr_en   (cmp_valid && (op == OP_LRMW_WR)),
        .in_addr  (cmp_addr),
        .qry_addr (qry_addr),
        .qry_hit  (qry_blocked)
    );

    // Register the response one cycle after the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_success <= 1'b0;
        end else begin
            rsp_valid   <= cmp_valid;
            rsp_success <= cmp_valid && (!is_sc || owned);
        end
    end

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> rsp_valid); // R10
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !rsp_valid && !rsp_success); // R10
    AST_NONSC_OK: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && (cmp_op != 3'd2) |=> rsp_success); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !rsp_success); // R9
endmodule

// File: tb/tb_llsc_monitor.sv
// Bench: behavioural queue model of reservations and holds, compared on
// every clock for the response and for the hold query.
module tb_llsc_monitor;
    localparam int AW = 16;
    localparam int IW = 4;
    localparam int NREC = 4;
    localparam int NBLK = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_valid = 1'b0;
    logic [AW-1:0] cmp_addr = '0;
    logic [2:0]    cmp_op = '0;
    logic [IW-1:0] cmp_owner = '0;
    logic [AW-1:0] qry_addr = '0;
    logic          rsp_valid, rsp_success, qry_blocked;

    always #2.5 clk = ~clk;

    llsc_monitor #(.AW(AW), .IW(IW), .NREC(NREC), .NBLK(NBLK)) dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_addr(cmp_addr),
        .cmp_op(cmp_op), .cmp_owner(cmp_owner), .qry_addr(qry_addr),
        .rsp_valid(rsp_valid), .rsp_success(rsp_success), .qry_blocked(qry_blocked)
    );

    typedef struct { logic [AW-1:0] line; logic [IW-1:0] who; } rec_t;
    rec_t          locks[$];
    logic [AW-1:0] holds[$];

    int    checks = 0;
    int    errors = 0;
    bit    exp_v = 0;
    bit    exp_s = 0;
    string exp_tag = "R10";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit held(input logic [AW-1:0] a);
        foreach (holds[i]) if (holds[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    // Apply one operation to the model; returns the expected success flag.
    function automatic bit model_op(input logic [2:0] o, input logic [AW-1:0] a,
                                    input logic [IW-1:0] w);
        int idx = -1;
        bit ok = 1'b1;
        foreach (locks[i]) if (locks[i].line == a) idx = i;
        if (o == 3'd1) begin
            if (idx >= 0) locks[idx].who = w;
            else begin
                if (locks.size() == NREC) void'(locks.pop_front());
                locks.push_back('{line: a, who: w});
            end
        end else if (o == 3'd2) begin
            ok = (idx >= 0) && (locks[idx].who == w);
            if (idx >= 0) locks.delete(idx);
        end else if ((idx >= 0) && (locks[idx].who == w)) begin
            locks.delete(idx);
        end
        if (o == 3'd3) begin
            if (!held(a) && (holds.size() < NBLK)) holds.push_back(a);
        end else if (o == 3'd4) begin
            for (int i = holds.size() - 1; i >= 0; i--)
                if (holds[i] == a) holds.delete(i);
        end
        return ok;
    endfunction

    // One cycle: compare outputs of the previous cycle, then drive the next.
    task automatic step(input bit v, input logic [2:0] o, input logic [AW-1:0] a,
                        input logic [IW-1:0] w, input logic [AW-1:0] q, input string tag);
        @(negedge clk);
        chk(rsp_valid == exp_v, "R10 rsp_valid", int'(rsp_valid), int'(exp_v));
        if (exp_v) chk(rsp_success == exp_s, exp_tag, int'(rsp_success), int'(exp_s));
        else chk(rsp_success == 1'b0, "R10 idle success", int'(rsp_success), 0);
        chk(qry_blocked == held(qry_addr), "R6 qry_blocked",
            int'(qry_blocked), int'(held(qry_addr)));
        exp_v = v && rst_n;
        exp_s = 1'b0;
        if (exp_v) exp_s = model_op(o, a, w);
        exp_tag = tag;
        cmp_valid = v;
        cmp_op = o;
        cmp_addr = a;
        cmp_owner = w;
        qry_addr = q;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmp_valid = 1'b0;
        locks.delete();
        holds.delete();
        exp_v = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk(rsp_valid == 1'b0, "R9 reset rsp_valid", int'(rsp_valid), 0);
        chk(qry_blocked == 1'b0, "R9 reset qry_blocked", int'(qry_blocked), 0);

        // R1, R2, R3: same owner succeeds once, second attempt fails
        step(1, 3'd1, 16'd10, 4'd1, 16'd0, "R1 load-linked success");
        step(1, 3'd2, 16'd10, 4'd1, 16'd0, "R2 sc same owner");
        step(1, 3'd2, 16'd10, 4'd1, 16'd0, "R3 sc after sc");
        // R2, R3: foreign sc fails and still clears
        step(1, 3'd1, 16'd20, 4'd2, 16'd0, "R1 load-linked success");
        step(1, 3'd2, 16'd20, 4'd3, 16'd0, "R2 sc other owner");
        step(1, 3'd2, 16'd20, 4'd2, 16'd0, "R3 sc after failed sc");
        // R4: store by stranger keeps, store by owner clears; flush too
        step(1, 3'd1, 16'd30, 4'd1, 16'd0, "R1 load-linked success");
        step(1, 3'd0, 16'd30, 4'd2, 16'd0, "R5 store success");
        step(1, 3'd2, 16'd30, 4'd1, 16'd0, "R4 sc after foreign store");
        step(1, 3'd1, 16'd30, 4'd1, 16'd0, "R1 load-linked success");
        step(1, 3'd0, 16'd30, 4'd1, 16'd0, "R5 store success");
        step(1, 3'd2, 16'd30, 4'd1, 16'd0, "R4 sc after own store");
        step(1, 3'd1, 16'd31, 4'd1, 16'd0, "R1 load-linked success");
        step(1, 3'd5, 16'd31, 4'd1, 16'd0, "R5 flush success");
        step(1, 3'd2, 16'd31, 4'd1, 16'd0, "R4 sc after own flush");

        // R7: five distinct lines, the first one is displaced
        do_reset();
        for (int i = 0; i < 5; i++)
            step(1, 3'd1, 16'(40 + i), 4'd1, 16'd0, "R7 fill");
        step(1, 3'd2, 16'd40, 4'd1, 16'd0, "R7 oldest displaced");
        step(1, 3'd2, 16'd41, 4'd1, 16'd0, "R7 second kept");

        // R8: overwrite keeps age, new owner wins
        do_reset();
        for (int i = 0; i < 4; i++)
            step(1, 3'd1, 16'(60 + i), 4'd1, 16'd0, "R7 fill");
        step(1, 3'd1, 16'd60, 4'd5, 16'd0, "R8 overwrite owner");
        step(1, 3'd1, 16'd64, 4'd1, 16'd0, "R7 displace");
        step(1, 3'd2, 16'd60, 4'd5, 16'd0, "R8 overwritten record still oldest");
        step(1, 3'd1, 16'd50, 4'd1, 16'd0, "R1 load-linked success");
        step(1, 3'd1, 16'd50, 4'd2, 16'd0, "R8 overwrite owner");
        step(1, 3'd2, 16'd50, 4'd1, 16'd0, "R8 old owner fails");

        // R6, R11: holds
        step(1, 3'd3, 16'd70, 4'd1, 16'd70, "R6 locked read");
        step(1, 3'd3, 16'd70, 4'd2, 16'd70, "R11 repeated hold");
        step(1, 3'd3, 16'd71, 4'd1, 16'd71, "R6 locked read");
        step(1, 3'd3, 16'd72, 4'd1, 16'd72, "R11 hold list full");
        step(1, 3'd4, 16'd70, 4'd1, 16'd70, "R6 locked write");
        step(1, 3'd3, 16'd72, 4'd1, 16'd72, "R11 slot reused");
        step(0, 3'd0, 16'd0, 4'd0, 16'd72, "R10 idle");

        // R9: reset clears reservations and holds
        step(1, 3'd1, 16'd80, 4'd1, 16'd0, "R1 load-linked success");
        do_reset();
        step(1, 3'd2, 16'd80, 4'd1, 16'd72, "R9 sc after reset");
        step(0, 3'd0, 16'd0, 4'd0, 16'd71, "R10 idle");
        step(0, 3'd0, 16'd0, 4'd0, 16'd0, "R10 idle");

        // Random mix over a small line set
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] o = 3'($urandom_range(0, 7));
            string t = (o == 3'd2) ? "R2 random sc" : "R5 random op";
            step(bit'($urandom_range(0, 3) != 0), o, 16'($urandom_range(0, 7)),
                 4'($urandom_range(0, 3)), 16'($urandom_range(0, 7)), t);
        end
        step(0, 3'd0, 16'd0, 4'd0, 16'd0, "R10 idle");
        step(0, 3'd0, 16'd0, 4'd0, 16'd0, "R10 idle");
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule